// File: doc/BRIEF.md
# Joinable Two-Channel Pulse-Width Modulator

This block produces two pulse-width modulated outputs from a pair of channels, named low and high. Each channel owns a counter, a period value, a duty value and four control bits: run enable, output polarity, centre alignment and clock-enable choice. The counters advance only on clock cycles where the chosen one of two shared clock-enable inputs is high, so the prescaler lives outside the block. A narrow register bus, one channel-width wide, writes and reads all settings.

Setting the join bit fuses the pair into a single channel of twice the width. The high channel's counter, period and duty then act as the upper half of the joined values. The low channel's control bits steer the joined channel. The high channel's control bits are kept but have no effect, and the high output is held low.

Register map (4-bit address; every register is CH_WIDTH bits, unused upper bits read as zero): 0 low control, 1 high control, 2 mode (bit 0 = join), 3 low counter, 4 high counter, 5 low period, 6 high period, 7 low duty, 8 high duty. Control bit positions: bit 0 enable, bit 1 polarity, bit 2 centre alignment, bit 3 clock choice.

Top module: `pwmPair`

## Requirements
- R1: Left-aligned (control bit 2 = 0) with period P > 0: the counter steps 0, 1, …, P-1, 0, … once per tick. The output is at the active level while the counter is below duty D and at the opposite level otherwise. Polarity bit 1 = 1 makes the active level high; 0 makes it low.
- R2: Centre-aligned (control bit 2 = 1) with P > 0: per tick the counter steps up from 0 to P, then down to 1, then wraps to 0. One cycle lasts 2·P ticks. The output level follows the R1 rule from the current count.
- R3: If D ≥ P, or if P = 0, the output stays at the active level for every tick of the period.
- R4: Writes to the period and duty registers land in a buffer. The buffer takes effect on the tick that ends the current period, or at every clock while the channel is disabled.
- R5: A disabled channel (control bit 0 = 0) drives its output 0 and holds its counter at 0.
- R6: Clock choice bit 3 = 0 counts on clkEnA and bit 3 = 1 counts on clkEnB. The counter does not move on a cycle where the chosen enable is low.
- R7: With the join bit clear, each channel runs on its own control bits, counter, period, duty and output.
- R8: With the join bit set, the counter, period and duty are the concatenation {high, low}. Enable, polarity, alignment and clock choice come from the low control register. The high control register has no effect.
- R9: With the join bit set, pwmHi is 0 at all times.
- R10: A bus write to a counter address clears that channel's counter whatever the data. With the join bit set, a write to either counter address clears the whole joined counter.
- R11: With the join bit set, a read of address 4 captures the low counter byte at that clock. The next read of address 3 returns the captured byte, so the two reads together give one coherent count.
- R12: After reset every register reads 0 and both outputs are 0. The control, mode, period and duty registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEnA | input | 1 | Count enable source A |
| clkEnB | input | 1 | Count enable source B |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | CH_WIDTH | Write data |
| busRdEn | input | 1 | Read strobe, one clock per read (drives read side effects) |
| busRdData | output | CH_WIDTH | Read data for busAddr, combinational |
| pwmLo | output | 1 | Low channel or joined output |
| pwmHi | output | 1 | High channel output |

## Verification
The bench builds the block with CH_WIDTH = 4. Each channel is then a nibble and the joined channel is a byte. Every period from 0 to 9 and every duty from 0 to 10 can be swept in both alignments, with both channels running different settings at once. In joined mode, periods that cross the nibble boundary (16, 17, 45) are reached in a few hundred cycles. This exercises the carry between halves and makes the coherent counter read meaningful, since the low nibble wraps between the two reads.

// File: rtl/pwmPairPkg.sv
`timescale 1ns/1ps
package pwmPairPkg;
  localparam int ADDR_W   = 4;
  localparam int CFG_BITS = 4;
  localparam int CFG_EN   = 0;
  localparam int CFG_POL  = 1;
  localparam int CFG_CTR  = 2;
  localparam int CFG_SEL  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG_LO  = 4'd0,
    REG_CFG_HI  = 4'd1,
    REG_MODE    = 4'd2,
    REG_CNT_LO  = 4'd3,
    REG_CNT_HI  = 4'd4,
    REG_PER_LO  = 4'd5,
    REG_PER_HI  = 4'd6,
    REG_DUTY_LO = 4'd7,
    REG_DUTY_HI = 4'd8
  } regAddr_e;

  typedef struct packed {
    logic       cat;
    logic [1:0] sel;
    logic [1:0] center;
    logic [1:0] pol;
    logic [1:0] en;
  } pwmCfg_t;

  typedef struct packed {
    logic [1:0] cntClr;
  } pwmStrobe_t;
endpackage

// File: rtl/pwmPairStep.sv
`timescale 1ns/1ps
module pwmPairStep #(
  parameter int N = 8
) (
  input  logic [N-1:0] cnt,
  input  logic [N-1:0] per,
  input  logic [N-1:0] duty,
  input  logic         countUp,
  input  logic         center,
  input  logic         tick,
  output logic [N-1:0] nextCnt,
  output logic         nextUp,
  output logic         periodEnd,
  output logic         inActive
);
  localparam logic [N-1:0] ONE = N'(1);

  always_comb begin
    nextCnt   = cnt;
    nextUp    = countUp;
    periodEnd = 1'b0;
    if (tick) begin
      if (per == '0) begin
        nextCnt   = '0;
        nextUp    = 1'b1;
        periodEnd = 1'b1;
      end else if (!center) begin
        nextUp = 1'b1;
        if (cnt >= per - ONE) begin
          nextCnt   = '0;
          periodEnd = 1'b1;
        end else begin
          nextCnt = cnt + ONE;
        end
      end else if (countUp) begin
        if (cnt >= per) begin
          nextCnt = cnt - ONE;
          nextUp  = 1'b0;
        end else begin
          nextCnt = cnt + ONE;
          nextUp  = (cnt + ONE) < per;
        end
      end else begin
        if (cnt <= ONE) begin
          nextCnt   = '0;
          nextUp    = 1'b1;
          periodEnd = 1'b1;
        end else begin
          nextCnt = cnt - ONE;
        end
      end
    end
  end

  assign inActive = (per == '0) || (duty >= per) || (cnt < duty);
endmodule

// File: rtl/pwmPairCtrl.sv
`timescale 1ns/1ps
module pwmPairCtrl
  import pwmPairPkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic [W-1:0]          wrData,
  input  logic                  rdEn,
  output logic [W-1:0]          rdData,
  input  logic [1:0][W-1:0]     cnt,
  output pwmCfg_t               cfg,
  output pwmStrobe_t            strb,
  output logic [1:0][W-1:0]     perBuf,
  output logic [1:0][W-1:0]     dutyBuf
);
  logic [1:0][CFG_BITS-1:0] cfgReg;
  logic                     catReg;
  logic [W-1:0]             latchLo;
  logic                     latchValid;
  logic                     hitCntLo, hitCntHi;

  assign hitCntLo = (addr == REG_CNT_LO);
  assign hitCntHi = (addr == REG_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg     <= '0;
      catReg     <= 1'b0;
      perBuf     <= '0;
      dutyBuf    <= '0;
      latchLo    <= '0;
      latchValid <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          REG_CFG_LO:  cfgReg[0]  <= wrData[CFG_BITS-1:0];
          REG_CFG_HI:  cfgReg[1]  <= wrData[CFG_BITS-1:0];
          REG_MODE:    catReg     <= wrData[0];
          REG_PER_LO:  perBuf[0]  <= wrData;
          REG_PER_HI:  perBuf[1]  <= wrData;
          REG_DUTY_LO: dutyBuf[0] <= wrData;
          REG_DUTY_HI: dutyBuf[1] <= wrData;
          default: ;
        endcase
      end
      if (rdEn && hitCntHi && catReg) begin
        latchLo    <= cnt[0];
        latchValid <= 1'b1;
      end else if (rdEn && hitCntLo) begin
        latchValid <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      cfg.en[i]     = cfgReg[i][CFG_EN];
      cfg.pol[i]    = cfgReg[i][CFG_POL];
      cfg.center[i] = cfgReg[i][CFG_CTR];
      cfg.sel[i]    = cfgReg[i][CFG_SEL];
    end
    cfg.cat = catReg;
  end

  assign strb.cntClr[0] = wrEn && (hitCntLo || (catReg && hitCntHi));
  assign strb.cntClr[1] = wrEn && (hitCntHi || (catReg && hitCntLo));

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CFG_LO:  rdData = W'(cfgReg[0]);
      REG_CFG_HI:  rdData = W'(cfgReg[1]);
      REG_MODE:    rdData = W'(catReg);
      REG_CNT_LO:  rdData = (catReg && latchValid) ? latchLo : cnt[0];
      REG_CNT_HI:  rdData = cnt[1];
      REG_PER_LO:  rdData = perBuf[0];
      REG_PER_HI:  rdData = perBuf[1];
      REG_DUTY_LO: rdData = dutyBuf[0];
      REG_DUTY_HI: rdData = dutyBuf[1];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwmPairDatapath.sv
`timescale 1ns/1ps
module pwmPairDatapath
  import pwmPairPkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnA,
  input  logic              clkEnB,
  input  pwmCfg_t           cfg,
  input  pwmStrobe_t        strb,
  input  logic [1:0][W-1:0] perBuf,
  input  logic [1:0][W-1:0] dutyBuf,
  output logic [1:0][W-1:0] cnt,
  output logic              pwmLo,
  output logic              pwmHi
);
  localparam int JW = 2 * W;

  logic [1:0][W-1:0] perAct, dutyAct;
  logic [1:0]        upR;
  logic [1:0]        tick;
  logic [1:0][W-1:0] chNext;
  logic [1:0]        chUp, chEnd, chAct;
  logic [JW-1:0]     catNext;
  logic              catUp, catEnd, catAct;

  for (genvar i = 0; i < 2; i++) begin : gCh
    assign tick[i] = cfg.en[i] && (cfg.sel[i] ? clkEnB : clkEnA);
    pwmPairStep #(.N(W)) uStep (
      .cnt(cnt[i]), .per(perAct[i]), .duty(dutyAct[i]),
      .countUp(upR[i]), .center(cfg.center[i]), .tick(tick[i]),
      .nextCnt(chNext[i]), .nextUp(chUp[i]),
      .periodEnd(chEnd[i]), .inActive(chAct[i])
    );
  end

  pwmPairStep #(.N(JW)) uStepCat (
    .cnt(cnt), .per(perAct), .duty(dutyAct),
    .countUp(upR[0]), .center(cfg.center[0]), .tick(tick[0]),
    .nextCnt(catNext), .nextUp(catUp),
    .periodEnd(catEnd), .inActive(catAct)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      upR     <= '1;
      perAct  <= '0;
      dutyAct <= '0;
    end else if (cfg.cat) begin
      if (!cfg.en[0]) begin
        cnt     <= '0;
        upR     <= '1;
        perAct  <= perBuf;
        dutyAct <= dutyBuf;
      end else if (|strb.cntClr) begin
        cnt    <= '0;
        upR[0] <= 1'b1;
      end else begin
        cnt    <= catNext;
        upR[0] <= catUp;
        if (catEnd) begin
          perAct  <= perBuf;
          dutyAct <= dutyBuf;
        end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!cfg.en[i]) begin
          cnt[i]     <= '0;
          upR[i]     <= 1'b1;
          perAct[i]  <= perBuf[i];
          dutyAct[i] <= dutyBuf[i];
        end else if (strb.cntClr[i]) begin
          cnt[i] <= '0;
          upR[i] <= 1'b1;
        end else begin
          cnt[i] <= chNext[i];
          upR[i] <= chUp[i];
          if (chEnd[i]) begin
            perAct[i]  <= perBuf[i];
            dutyAct[i] <= dutyBuf[i];
          end
        end
      end
    end
  end

  logic loActive;
  assign loActive = cfg.cat ? catAct : chAct[0];
  assign pwmLo = cfg.en[0] && (loActive ? cfg.pol[0] : !cfg.pol[0]);
  assign pwmHi = !cfg.cat && cfg.en[1] && (chAct[1] ? cfg.pol[1] : !cfg.pol[1]);
endmodule

// File: rtl/pwmPair.sv
`timescale 1ns/1ps
module pwmPair
  import pwmPairPkg::*;
#(
  parameter int CH_WIDTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEnA,
  input  logic                clkEnB,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [CH_WIDTH-1:0] busWrData,
  input  logic                busRdEn,
  output logic [CH_WIDTH-1:0] busRdData,
  output logic                pwmLo,
  output logic                pwmHi
);
  pwmCfg_t                  cfgBus;
  pwmStrobe_t               strbBus;
  logic [1:0][CH_WIDTH-1:0] cntAll, perBuf, dutyBuf;

  pwmPairCtrl #(.W(CH_WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(busWrEn),
    .wrData(busWrData), .rdEn(busRdEn), .rdData(busRdData),
    .cnt(cntAll), .cfg(cfgBus), .strb(strbBus),
    .perBuf(perBuf), .dutyBuf(dutyBuf)
  );

  pwmPairDatapath #(.W(CH_WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .clkEnA(clkEnA), .clkEnB(clkEnB),
    .cfg(cfgBus), .strb(strbBus), .perBuf(perBuf), .dutyBuf(dutyBuf),
    .cnt(cntAll), .pwmLo(pwmLo), .pwmHi(pwmHi)
  );
endmodule

// File: rtl/pwmPairChecker.sv
`timescale 1ns/1ps
module pwmPairChecker
  import pwmPairPkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnA,
  input logic              clkEnB,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input pwmCfg_t           cfg,
  input logic [1:0][W-1:0] cnt,
  input logic              pwmLo,
  input logic              pwmHi
);
  logic loTick;
  assign loTick = cfg.sel[0] ? clkEnB : clkEnA;

  assert_hi_quiet_joined_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfg.cat |-> !pwmHi);

  assert_joined_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_CNT_HI && cfg.cat) |=> (cnt == '0));

  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !cfg.cat && cfg.en[0] && !loTick) |=> $stable(cnt[0]));

  assert_left_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !cfg.cat && cfg.en[0] && !cfg.center[0] && loTick)
      |=> (cnt[0] == $past(cnt[0]) + W'(1)) || (cnt[0] == '0));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en[0] && !busWrEn) |=> (cnt[0] == '0) && !pwmLo);
endmodule

bind pwmPair pwmPairChecker #(.W(CH_WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .clkEnA(clkEnA), .clkEnB(clkEnB),
  .busAddr(busAddr), .busWrEn(busWrEn), .cfg(cfgBus), .cnt(cntAll),
  .pwmLo(pwmLo), .pwmHi(pwmHi)
);

// File: tb/pwmPair_test.sv
`timescale 1ns/1ps
module pwmPair_test;
  localparam int W = 4;
  localparam logic [3:0] A_CFG_LO = 4'd0, A_CFG_HI = 4'd1, A_MODE = 4'd2,
                         A_CNT_LO = 4'd3, A_CNT_HI = 4'd4, A_PER_LO = 4'd5,
                         A_PER_HI = 4'd6, A_DUTY_LO = 4'd7, A_DUTY_HI = 4'd8;

  logic         clk = 1'b0, rstN = 1'b0, clkEnA = 1'b1, clkEnB = 1'b0;
  logic [3:0]   busAddr = '0;
  logic         busWrEn = 1'b0, busRdEn = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic         pwmLo, pwmHi;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  pwmPair #(.CH_WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .clkEnA(clkEnA), .clkEnB(clkEnB),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .pwmLo(pwmLo), .pwmHi(pwmHi)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input int d);
    busAddr = a; busWrData = W'(d); busWrEn = 1'b1; clkEnB = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output int v);
    busAddr = a; busRdEn = 1'b1; clkEnB = 1'b0;
    #1 v = int'(busRdData);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic bit model(input int n, input int p, input int d, input int pol, input int cen);
    int c, m;
    bit act;
    if (p == 0) act = 1;
    else begin
      if (cen != 0) begin
        m = n % (2 * p);
        c = (m <= p) ? m : 2 * p - m;
      end else c = n % p;
      act = (d >= p) || (c < d);
    end
    return act ? bit'(pol) : !bit'(pol);
  endfunction

  task automatic runPair(input bit cat,
                         input int pL, input int dL, input int polL, input int cenL, input int selL,
                         input int pH, input int dH, input int polH, input int cenH, input int selH,
                         input int cyc, input int switchAt, input int d2, input string tag);
    int nL, nH, errL, errH, lenL, lenH, bound, dNow, fAct, fExp;
    bit b, eL, eH;
    busWrite(A_CFG_LO, 0);
    busWrite(A_CFG_HI, 0);
    busWrite(A_MODE, int'(cat));
    if (cat) begin
      busWrite(A_PER_LO, pL & 15);  busWrite(A_PER_HI, pL >> 4);
      busWrite(A_DUTY_LO, dL & 15); busWrite(A_DUTY_HI, dL >> 4);
    end else begin
      busWrite(A_PER_LO, pL);  busWrite(A_PER_HI, pH);
      busWrite(A_DUTY_LO, dL); busWrite(A_DUTY_HI, dH);
    end
    busWrite(A_CFG_HI, 1 | (polH << 1) | (cenH << 2) | (selH << 3));
    busWrite(A_CFG_LO, 1 | (polL << 1) | (cenL << 2) | (selL << 3));
    nL = 0; nH = (cat || selH != 0) ? 0 : 1;
    errL = 0; errH = 0; bound = 1 << 30; fAct = 0; fExp = 0;
    lenL = (pL == 0) ? 1 : (cenL != 0 ? 2 * pL : pL);
    lenH = (pH == 0) ? 1 : (cenH != 0 ? 2 * pH : pH);
    for (int k = 0; k < cyc; k++) begin
      dNow = (nL >= bound) ? d2 : dL;
      eL = model(nL, pL, dNow, polL, cenL);
      eH = cat ? 1'b0 : model(nH, pH, dH, polH, cenH);
      if (pwmLo !== eL) begin if (errL == 0) begin fAct = pwmLo; fExp = eL; end errL++; end
      if (pwmHi !== eH) errH++;
      b = (k % 3) != 0;
      clkEnB = b;
      if (k == switchAt) begin
        busAddr = A_DUTY_LO; busWrData = W'(d2); busWrEn = 1'b1;
        bound = (nL / lenL + 1) * lenL;
        if (nL % lenL == lenL - 1) bound += lenL;
      end
      @(negedge clk);
      busWrEn = 1'b0;
      nL += (selL != 0) ? int'(b) : 1;
      nH += (selH != 0) ? int'(b) : 1;
    end
    clkEnB = 1'b0;
    check(errL == 0, $sformatf("%s lo P=%0d D=%0d cen=%0d", tag, pL, dL, cenL), fAct, fExp);
    check(errH == 0, $sformatf("%s hi P=%0d D=%0d cat=%0d", tag, pH, dH, cat), errH, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int v, hiV, loV, mm;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state of every register and both outputs
    mm = 0;
    for (int a = 0; a <= 8; a++) begin
      busRead(4'(a), v);
      if (v != 0) mm++;
    end
    check(mm == 0, "R12 registers zero after reset", mm, 0);
    check(pwmLo == 1'b0 && pwmHi == 1'b0, "R12 outputs zero after reset", int'({pwmLo, pwmHi}), 0);
    busWrite(A_PER_LO, 11); busRead(A_PER_LO, v);
    check(v == 11, "R12 period readback", v, 11);
    busWrite(A_CFG_HI, 6); busRead(A_CFG_HI, v);
    check(v == 6, "R12 control readback", v, 6);
    busWrite(A_DUTY_HI, 9); busRead(A_DUTY_HI, v);
    check(v == 9, "R12 duty readback", v, 9);

    // R1 R2 R3 R6 R7: independent sweep, both channels in different settings
    for (int p = 0; p <= 9; p++)
      for (int d = 0; d <= 10; d++)
        for (int c = 0; c < 2; c++) begin
          int pH, dH, lm;
          pH = (p + 4) % 10; dH = (d + 3) % 11;
          lm = 2 * ((p > pH ? p : pH) + 1) * 2 + 6;
          runPair(1'b0, p, d, (p + d) % 2, c, int'(d % 3 == 0),
                  pH, dH, 1 - (p + d) % 2, 1 - c, int'(d % 3 != 0),
                  lm, -1, 0, "R1 R2 R3 R6 R7");
        end

    // R8 R9 R3 R6: joined sweep, high controls set to conflicting values
    for (int pi = 0; pi < 6; pi++)
      for (int di = 0; di < 5; di++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++) begin
            int p, d, len;
            p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 7 : (pi == 3) ? 16 : (pi == 4) ? 17 : 45;
            d = (di == 0) ? 0 : (di == 1) ? 3 : (di == 2) ? 16 : (di == 3) ? p : p + 1;
            len = (c != 0) ? 2 * p : p;
            runPair(1'b1, p, d, (pi + di) % 2, c, s,
                    0, 0, 1 - (pi + di) % 2, 1 - c, 1 - s,
                    3 * len + 8, -1, 0, "R8 R9 joined");
          end

    // R4: buffered duty takes effect only at the period boundary
    runPair(1'b0, 6, 2, 1, 0, 0, 3, 1, 0, 0, 0, 30, 3, 5, "R4 left buffer");
    runPair(1'b0, 4, 1, 0, 1, 0, 5, 2, 1, 1, 0, 30, 5, 3, "R4 centre buffer");

    // R11 and R10 (joined): coherent read then clear by writing the high byte
    runPair(1'b1, 200, 100, 1, 0, 0, 0, 0, 0, 0, 0, 31, -1, 0, "R11 setup");
    busRead(A_CNT_HI, hiV);
    repeat (3) @(negedge clk);
    busRead(A_CNT_LO, loV);
    check((hiV * 16 + loV) == 31, "R11 coherent joined count", hiV * 16 + loV, 31);
    busWrite(A_CNT_HI, 5);
    busRead(A_CNT_HI, hiV);
    busRead(A_CNT_LO, loV);
    check(hiV == 0 && loV == 0, "R10 joined clear via high byte", hiV * 16 + loV, 0);

    // R10 (independent): clearing the low counter leaves the high one running
    runPair(1'b0, 9, 4, 1, 0, 0, 9, 4, 1, 0, 0, 5, -1, 0, "R10 setup");
    busWrite(A_CNT_LO, 7);
    busRead(A_CNT_LO, loV);
    check(loV == 0, "R10 low counter cleared", loV, 0);
    busRead(A_CNT_HI, hiV);
    check(hiV == 8, "R10 high counter untouched", hiV, 8);

    // R5 and R8: joined with low disabled but high enabled stays idle
    busWrite(A_CFG_LO, 2);
    busWrite(A_CFG_HI, 1 | 2);
    busWrite(A_MODE, 1);
    repeat (5) @(negedge clk);
    check(pwmLo == 1'b0, "R5 disabled joined output low", pwmLo, 0);
    check(pwmHi == 1'b0, "R8 high enable ignored", pwmHi, 0);
    busRead(A_CNT_HI, hiV);
    busRead(A_CNT_LO, loV);
    check(hiV == 0 && loV == 0, "R5 disabled counter held at zero", hiV * 16 + loV, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule